// File: doc/BRIEF.md
# Word-Serial Iterative AES-128 Encryption Engine

This block encrypts one 128-bit block under a 128-bit cipher key. It exchanges data only through 32-bit words. A host writes four plaintext words and four key words on one shared input bus, in any order and with gaps between them. Once both operands are complete, the engine runs the cipher on a single round datapath that is used again on every clock, so one round finishes per cycle. Each round key is derived from the previous one at the time it is needed, so no key schedule is stored.

After the tenth round the ciphertext leaves the engine as four 32-bit words on consecutive cycles, each one marked by a ready strobe. A one-cycle completion pulse follows the last word. The engine then drops its operand flags and is ready for the next block. While a block is being processed, the input bus has no effect on the engine.

Top module: `aes_word_engine`

## Requirements
- R1: A cycle with `in_valid`=1 and `in_sel`=0 stores `in_word` as the next plaintext word. The first word written becomes bits 127:96 of the block, which hold the first byte of the block in bits 127:120. `data_loaded` goes high at the clock edge that stores the fourth word.
- R2: A cycle with `in_valid`=1 and `in_sel`=1 stores `in_word` as the next key word, in the same order as R1. `key_loaded` goes high at the clock edge that stores the fourth key word.
- R3: A word addressed to an operand that already holds four words is ignored. Every word presented from the edge that completes both operands until `done` has fallen is also ignored.
- R4: `out_ready` first goes high 11 clock edges after the edge that stores the last operand word. This is one edge for the initial key addition and one edge per round for ten rounds.
- R5: The ciphertext is the AES-128 encryption of the loaded plaintext under the loaded key. An initial key addition comes first. Rounds 1 to 9 each apply substitution, row rotation, column mixing and key addition. Round 10 leaves out the column mixing.
- R6: The order of the operand words on the bus does not matter. Key first, plaintext first, interleaved words and idle cycles between words all give the same ciphertext.
- R7: `out_ready` is high for exactly four consecutive cycles. `out_word` carries ciphertext bits 127:96, then 95:64, then 63:32, then 31:0, and is zero whenever `out_ready` is low.
- R8: `done` is high for exactly one cycle, the cycle right after the last ciphertext word. At the end of that cycle both loaded flags clear, and a word presented in the next cycle is accepted.
- R9: After reset `out_ready`, `done`, `data_loaded`, `key_loaded` and `out_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is present on `in_word` |
| in_sel | input | 1 | Target of the word: 0 for plaintext, 1 for key |
| in_word | input | 32 | Operand word |
| data_loaded | output | 1 | All four plaintext words are stored |
| key_loaded | output | 1 | All four key words are stored |
| out_ready | output | 1 | `out_word` carries a ciphertext word |
| out_word | output | 32 | Ciphertext word, most significant first |
| done | output | 1 | One-cycle pulse after the last ciphertext word |

## Verification
Two functions can fall in the same cycle: unloading the ciphertext (and the `done` pulse after it), and a host writing a new operand word. The bench provokes this by driving random words with a random `in_sel` on the bus through the whole run, unload and `done` window. It judges the outcome by checking three things: the loaded flags stay as they were, the ciphertext matches an independent model of the cipher, and the very next word after `done` counts as the first word of the next block.

// File: rtl/aes_word_engine.sv
module aes_word_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sel,
  input  logic [31:0] in_word,
  output logic        data_loaded,
  output logic        key_loaded,
  output logic        out_ready,
  output logic [31:0] out_word,
  output logic        done
);
  localparam int NROUNDS = 10;

  typedef enum logic [1:0] {IDLE, RUN, UNLOAD, FIN} phase_t;

  phase_t       phase_q;
  logic [127:0] pt_q, key_q, st_q, rk_q;
  logic [2:0]   dcnt, kcnt;
  logic [3:0]   rnd;
  logic [7:0]   rcon;
  logic [1:0]   ocnt;
  logic [127:0] nk, st_next;
  logic [31:0]  sel_word;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] p, r;
    p = a;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] key_step(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] t, n0, n1, n2, n3;
    t  = {sbox(k[23:16]), sbox(k[15:8]), sbox(k[7:0]), sbox(k[31:24])} ^ {rc, 24'h0};
    n0 = k[127:96] ^ t;
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0] ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [127:0] round_step(input logic [127:0] s, input logic [127:0] k,
                                              input logic last);
    logic [7:0] a [16];
    logic [7:0] m [16];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        a[4*c+r] = sbox(s[127-8*(4*((c+r)%4)+r) -: 8]);
    for (int c = 0; c < 4; c++) begin
      if (last) begin
        for (int r = 0; r < 4; r++) m[4*c+r] = a[4*c+r];
      end else begin
        m[4*c]   = xt(a[4*c]) ^ xt(a[4*c+1]) ^ a[4*c+1] ^ a[4*c+2] ^ a[4*c+3];
        m[4*c+1] = a[4*c] ^ xt(a[4*c+1]) ^ xt(a[4*c+2]) ^ a[4*c+2] ^ a[4*c+3];
        m[4*c+2] = a[4*c] ^ a[4*c+1] ^ xt(a[4*c+2]) ^ xt(a[4*c+3]) ^ a[4*c+3];
        m[4*c+3] = xt(a[4*c]) ^ a[4*c] ^ a[4*c+1] ^ a[4*c+2] ^ xt(a[4*c+3]);
      end
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = m[i] ^ k[127-8*i -: 8];
    return o;
  endfunction

  assign nk          = key_step(rk_q, rcon);
  assign st_next     = round_step(st_q, nk, rnd == 4'(NROUNDS));
  assign data_loaded = dcnt[2];
  assign key_loaded  = kcnt[2];
  assign out_ready   = (phase_q == UNLOAD);
  assign done        = (phase_q == FIN);
  assign out_word    = out_ready ? sel_word : 32'h0;

  always_comb begin
    case (ocnt)
      2'd0:    sel_word = st_q[127:96];
      2'd1:    sel_word = st_q[95:64];
      2'd2:    sel_word = st_q[63:32];
      default: sel_word = st_q[31:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= IDLE;
      pt_q    <= '0;
      key_q   <= '0;
      st_q    <= '0;
      rk_q    <= '0;
      dcnt    <= '0;
      kcnt    <= '0;
      rnd     <= '0;
      rcon    <= '0;
      ocnt    <= '0;
    end else begin
      case (phase_q)
        IDLE: begin
          if (dcnt[2] && kcnt[2]) begin
            st_q    <= pt_q ^ key_q;
            rk_q    <= key_q;
            rnd     <= 4'd1;
            rcon    <= 8'h01;
            phase_q <= RUN;
          end else if (in_valid) begin
            if (!in_sel && !dcnt[2]) begin
              pt_q <= {pt_q[95:0], in_word};
              dcnt <= dcnt + 3'd1;
            end
            if (in_sel && !kcnt[2]) begin
              key_q <= {key_q[95:0], in_word};
              kcnt  <= kcnt + 3'd1;
            end
          end
        end
        RUN: begin
          st_q <= st_next;
          rk_q <= nk;
          rcon <= xt(rcon);
          rnd  <= rnd + 4'd1;
          if (rnd == 4'(NROUNDS)) begin
            ocnt    <= 2'd0;
            phase_q <= UNLOAD;
          end
        end
        UNLOAD: begin
          ocnt <= ocnt + 2'd1;
          if (ocnt == 2'd3) phase_q <= FIN;
        end
        default: begin
          dcnt    <= '0;
          kcnt    <= '0;
          phase_q <= IDLE;
        end
      endcase
    end
  end
endmodule

module aes_word_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        data_loaded,
  input logic        key_loaded,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        done
);
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n) !(out_ready && done));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_unload_end_R7: assert property (@(posedge clk) disable iff (!rst_n) $fell(out_ready) |-> done);
  assert_flags_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> (data_loaded && key_loaded));
  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!data_loaded && !key_loaded));
  assert_data_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_loaded && !done) |=> data_loaded);
  assert_key_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_loaded && !done) |=> key_loaded);
  assert_zero_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (out_word == 32'h0));
endmodule

bind aes_word_engine aes_word_engine_chk chk (
  .clk(clk), .rst_n(rst_n), .data_loaded(data_loaded), .key_loaded(key_loaded),
  .out_ready(out_ready), .out_word(out_word), .done(done)
);

// File: tb/aes_word_engine_test.sv
module aes_word_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sel = 1'b0;
  logic [31:0] in_word = 32'h0;
  logic        data_loaded, key_loaded, out_ready, done;
  logic [31:0] out_word;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit running = 1'b1;

  logic [7:0]  sbt [256];
  logic [31:0] dq[$];
  logic [31:0] kq[$];
  int          k_edge = -1;
  logic [127:0] m_ct = '0;

  aes_word_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel), .in_word(in_word),
    .data_loaded(data_loaded), .key_loaded(key_loaded), .out_ready(out_ready),
    .out_word(out_word), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    int acc, aa;
    acc = 0;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa << 1;
      if (aa & 256) aa = aa ^ 'h11b;
    end
    return acc[7:0];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] w [44];
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [31:0] tmp;
    logic [7:0]  rc;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sbt[tmp[23:16]], sbt[tmp[15:8]], sbt[tmp[7:0]], sbt[tmp[31:24]]} ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int j = 0; j < 16; j++) s[j] = pt[127-8*j -: 8] ^ key[127-8*j -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int j = 0; j < 16; j++) t[j] = sbt[s[((j/4 + j%4) % 4)*4 + j%4]];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c]   = bmul(t[4*c],2) ^ bmul(t[4*c+1],3) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ bmul(t[4*c+1],2) ^ bmul(t[4*c+2],3) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ bmul(t[4*c+2],2) ^ bmul(t[4*c+3],3);
          s[4*c+3] = bmul(t[4*c],3) ^ t[4*c+1] ^ t[4*c+2] ^ bmul(t[4*c+3],2);
        end else begin
          for (int r2 = 0; r2 < 4; r2++) s[4*c+r2] = t[4*c+r2];
        end
        for (int r2 = 0; r2 < 4; r2++) s[4*c+r2] = s[4*c+r2] ^ w[4*r+c][31-8*r2 -: 8];
      end
    end
    for (int j = 0; j < 16; j++) res[127-8*j -: 8] = s[j];
    return res;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      dq.delete();
      kq.delete();
      k_edge = -1;
    end else if (k_edge >= 0) begin
      k_edge++;
      if (k_edge == 16) begin
        dq.delete();
        kq.delete();
        k_edge = -1;
      end
    end else if (in_valid) begin
      if (!in_sel && dq.size() < 4) dq.push_back(in_word);
      if (in_sel && kq.size() < 4) kq.push_back(in_word);
      if (dq.size() == 4 && kq.size() == 4) begin
        k_edge = 0;
        m_ct = ref_enc({kq[0], kq[1], kq[2], kq[3]}, {dq[0], dq[1], dq[2], dq[3]});
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      logic exp_rdy;
      logic [31:0] exp_w;
      exp_rdy = (k_edge >= 11 && k_edge <= 14);
      exp_w = exp_rdy ? m_ct[127-32*(k_edge-11) -: 32] : 32'h0;
      chk("R7 out_ready", {127'h0, out_ready}, {127'h0, exp_rdy});
      chk("R7/R5 out_word", {96'h0, out_word}, {96'h0, exp_w});
      chk("R8 done", {127'h0, done}, {127'h0, k_edge == 15});
      chk("R1/R3 data_loaded", {127'h0, data_loaded}, {127'h0, dq.size() == 4});
      chk("R2/R3 key_loaded", {127'h0, key_loaded}, {127'h0, kq.size() == 4});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && running) begin
      running = 1'b0;
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(input logic sel, input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_sel = sel;
    in_word = w;
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_block(input bit junk, input logic [127:0] exp, input string tag);
    logic [127:0] ct;
    int j;
    @(negedge clk);
    in_valid = junk;
    in_sel = 1'($urandom);
    in_word = $urandom;
    j = 0;
    while (!out_ready && j < 40) begin
      @(negedge clk);
      j++;
      if (junk) begin
        in_sel = 1'($urandom);
        in_word = $urandom;
      end
    end
    chk("R4 latency", 128'(j), 128'd11);
    for (int w = 0; w < 4; w++) begin
      ct[127-32*w -: 32] = out_word;
      @(negedge clk);
      if (junk) in_word = $urandom;
    end
    chk("R8 done pulse", {127'h0, done}, 128'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 flags clear", {126'h0, data_loaded, key_loaded}, 128'h0);
    chk(tag, ct, exp);
  endtask

  initial begin
    logic [127:0] kk, pp;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv, af;
      iv = 8'h00;
      for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      for (int b = 0; b < 8; b++)
        af[b] = iv[b] ^ iv[(b+4)%8] ^ iv[(b+5)%8] ^ iv[(b+6)%8] ^ iv[(b+7)%8] ^ ((8'h63 >> b) & 1);
      sbt[x] = af;
    end
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {91'h0, out_ready, done, data_loaded, key_loaded, out_word}, 128'h0);
    rst_n = 1'b1;

    send(0, 32'h00112233); send(0, 32'h44556677); send(0, 32'h8899aabb); send(0, 32'hccddeeff);
    send(1, 32'h00010203); send(1, 32'h04050607); send(1, 32'h08090a0b); send(1, 32'h0c0d0e0f);
    finish_block(0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5 known vector");

    for (int i = 0; i < 4; i++) send(1, 32'h0);
    for (int i = 0; i < 4; i++) send(0, 32'h0);
    finish_block(0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R6 key first zero vector");

    for (int n = 0; n < 6; n++) begin
      kk = {$urandom, $urandom, $urandom, $urandom};
      pp = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < 4; i++) begin
        send(1, kk[127-32*i -: 32]);
        if (n % 2 == 1) gap();
        send(0, pp[127-32*i -: 32]);
      end
      finish_block(1, ref_enc(kk, pp), "R3/R6 busy bus interleaved");
    end

    kk = {$urandom, $urandom, $urandom, $urandom};
    pp = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 4; i++) send(0, pp[127-32*i -: 32]);
    send(0, 32'hdeadbeef);
    send(0, 32'h12345678);
    for (int i = 0; i < 4; i++) send(1, kk[127-32*i -: 32]);
    finish_block(0, ref_enc(kk, pp), "R3 extra words ignored");

    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule